// File: doc/BRIEF.md
# Self-Routing Omega Network

This block is a P-input, P-output multistage interconnect for a power-of-two port count. A packet has a valid bit, a destination index and a payload. Its source index is given by the input port it enters on. The network has log2(P) stages. In each stage, a perfect-shuffle link pattern feeds a column of P/2 two-by-two switches. Each switch sets itself from the packets that arrive at it, so the network needs no central scheduler and no configuration state.

At stage k (counted from 0), a switch compares destination bit log2(P)-1-k with the matching bit of the packet's source position. The destination bits are therefore used from the most significant to the least significant. If two valid packets at one switch need different switch settings, the upper input is served and the lower packet is dropped. The flag for that stage and switch is then raised. Other logic uses these flags to decide what to send again. The network is combinational by default. A build parameter adds one register after every switch column.

Top module: `omega_net`

## Requirements
- R1: The network has log2(PORTS) stages of PORTS/2 switches each. `collision` is log2(PORTS)·PORTS/2 bits wide. Bit k·(PORTS/2)+i belongs to switch i of stage k, and stage 0 is the stage nearest the inputs.
- R2: When no flag is raised, each valid packet leaves on the output whose index equals its destination. Its valid bit is set and its payload is unchanged. A full load of uniform shifts (destination = source + c mod PORTS) raises no flag.
- R3: The links into every stage send position j to position (j rotated left by one bit within log2(PORTS) bits). The switch at stage k routes on destination bit log2(PORTS)-1-k.
- R4: A switch goes to pass-through when the positional source bit of a valid packet equals its destination bit, and to crossover otherwise. Pass-through sends upper to upper and lower to lower; crossover swaps them. As a result, a packet leaves a switch on the upper output when its routing bit is 0 and on the lower output when it is 1.
- R5: When both inputs of a switch are valid and need different settings, the switch takes the setting of the upper packet. The lower packet's valid bit is cleared, and that switch's `collision` bit is 1.
- R6: An invalid input places no constraint on its switch. A `collision` bit is never 1 unless both inputs of its switch carry valid packets.
- R7: An output that no packet reaches has its valid bit low.
- R8: With PIPELINE=0, outputs and flags follow the inputs in the same cycle. With PIPELINE=1, a packet appears log2(PORTS) rising edges after it is applied, and the flags of stage k appear k+1 edges after it is applied.
- R9: With PIPELINE=1, an active-low reset clears every stage register, so `out_valid` and `collision` read zero during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional stage registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | PORTS | Valid bit per input port |
| in_dest | input | PORTS·log2(PORTS) | Destination index per input, port j at bits j·log2(PORTS) upward |
| in_data | input | PORTS·PAY_W | Payload per input, port j at bits j·PAY_W upward |
| out_valid | output | PORTS | Valid bit per output port |
| out_data | output | PORTS·PAY_W | Payload per output port, same packing as in_data |
| collision | output | log2(PORTS)·PORTS/2 | Per-switch drop flags, laid out as in R1 |

## Verification
The bench builds two copies with PORTS=8 and PAY_W=8, one combinational and one with a register per stage, and drives both with the same inputs. At this size the bench can sweep every source-to-destination pair for a single packet, every uniform shift under full load, and several hundred random mixes of valid bits and destinations. The expected results come from a port-arithmetic model of the three stages. The pipelined copy also brings the three-edge latency and the reset state within reach of direct checks.

// File: rtl/omega_pkg.sv
package omega_pkg;

    typedef enum logic {
        SW_PASS  = 1'b0,
        SW_CROSS = 1'b1
    } sw_state_e;

    // Perfect shuffle: left rotate an index of idx_w bits by one place.
    function automatic int shuffle_idx(int idx, int idx_w);
        int top_bit;
        top_bit = (idx >> (idx_w - 1)) & 1;
        return ((idx << 1) & ((1 << idx_w) - 1)) | top_bit;
    endfunction

endpackage

// File: rtl/omega_switch.sv
module omega_switch
    import omega_pkg::*;
#(
    parameter int DST_W   = 3,
    parameter int PAY_W   = 8,
    parameter int SEL_BIT = 2
) (
    input  logic [DST_W+PAY_W:0] up_i,
    input  logic [DST_W+PAY_W:0] lo_i,
    output logic [DST_W+PAY_W:0] up_o,
    output logic [DST_W+PAY_W:0] lo_o,
    output logic                 clash_o
);
    typedef struct packed {
        logic             vld;
        logic [DST_W-1:0] dst;
        logic [PAY_W-1:0] pay;
    } pkt_t;

    pkt_t      up_pkt, lo_pkt, lo_kept, up_out, lo_out;
    sw_state_e up_want, lo_want, state;
    logic      clash;

    always_comb begin
        up_pkt  = pkt_t'(up_i);
        lo_pkt  = pkt_t'(lo_i);
        // Upper input sits at positional source bit 0, lower at 1:
        // pass-through when the destination bit matches that position bit.
        up_want = up_pkt.dst[SEL_BIT] ? SW_CROSS : SW_PASS;
        lo_want = lo_pkt.dst[SEL_BIT] ? SW_PASS  : SW_CROSS;
        clash   = 1'b0;
        if (up_pkt.vld) begin
            state = up_want;
            clash = lo_pkt.vld && (lo_want != up_want);
        end else if (lo_pkt.vld) begin
            state = lo_want;
        end else begin
            state = SW_PASS;
        end
        lo_kept = lo_pkt;
        if (clash) begin
            lo_kept.vld = 1'b0;
        end
        if (state == SW_CROSS) begin
            up_out = lo_kept;
            lo_out = up_pkt;
        end else begin
            up_out = up_pkt;
            lo_out = lo_kept;
        end
    end

    assign up_o    = up_out;
    assign lo_o    = lo_out;
    assign clash_o = clash;

endmodule

// File: rtl/omega_stage.sv
module omega_stage
    import omega_pkg::*;
#(
    parameter int PORTS   = 8,
    parameter int DST_W   = 3,
    parameter int PAY_W   = 8,
    parameter int SEL_BIT = 2,
    parameter bit PIPE    = 1'b0
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [PORTS*(1+DST_W+PAY_W)-1:0]   in_bus,
    output logic [PORTS*(1+DST_W+PAY_W)-1:0]   out_bus,
    output logic [PORTS/2-1:0]                 col_o
);
    localparam int PKT_W = 1 + DST_W + PAY_W;
    localparam int NSW   = PORTS / 2;

    typedef struct packed {
        logic [PORTS*PKT_W-1:0] bus;
        logic [NSW-1:0]         col;
    } stage_t;

    logic [PKT_W-1:0] shuf [PORTS];
    logic [PKT_W-1:0] swo  [PORTS];
    logic [NSW-1:0]   clash;
    logic [PORTS-1:0] shuf_v, swo_v;
    stage_t           st_d, st_q;

    for (genvar j = 0; j < PORTS; j++) begin : g_shuf
        localparam int DJ = shuffle_idx(j, DST_W);
        assign shuf[DJ]  = in_bus[j*PKT_W +: PKT_W];
        assign shuf_v[j] = shuf[j][PKT_W-1];
        assign swo_v[j]  = swo[j][PKT_W-1];
    end

    for (genvar i = 0; i < NSW; i++) begin : g_sw
        omega_switch #(
            .DST_W  (DST_W),
            .PAY_W  (PAY_W),
            .SEL_BIT(SEL_BIT)
        ) u_sw (
            .up_i   (shuf[2*i]),
            .lo_i   (shuf[2*i+1]),
            .up_o   (swo[2*i]),
            .lo_o   (swo[2*i+1]),
            .clash_o(clash[i])
        );
    end

    always_comb begin
        st_d     = '0;
        st_d.col = clash;
        for (int j = 0; j < PORTS; j++) begin
            st_d.bus[j*PKT_W +: PKT_W] = swo[j];
        end
    end

    if (PIPE) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end
    end else begin : g_comb
        assign st_q = st_d;
    end

    assign out_bus = st_q.bus;
    assign col_o   = st_q.col;

    // Packets are only lost where a flag is raised.
    assert_valid_conserve_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(swo_v) + $countones(clash)) == $countones(shuf_v));

    for (genvar i = 0; i < NSW; i++) begin : g_chk_sw
        assert_flag_needs_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
            clash[i] |-> (shuf_v[2*i] && shuf_v[2*i+1]));
        assert_upper_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
            clash[i] |-> ((swo[2*i] == shuf[2*i]) || (swo[2*i+1] == shuf[2*i])));
    end

    for (genvar j = 0; j < PORTS; j++) begin : g_chk_out
        // Upper output carries routing bit 0, lower carries 1.
        assert_route_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
            swo_v[j] |-> (swo[j][PAY_W+SEL_BIT] == 1'(j % 2)));
    end

endmodule

// File: rtl/omega_net.sv
module omega_net
    import omega_pkg::*;
#(
    parameter int PORTS    = 8,
    parameter int PAY_W    = 8,
    parameter bit PIPELINE = 1'b0
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [PORTS-1:0]                     in_valid,
    input  logic [PORTS*$clog2(PORTS)-1:0]       in_dest,
    input  logic [PORTS*PAY_W-1:0]               in_data,
    output logic [PORTS-1:0]                     out_valid,
    output logic [PORTS*PAY_W-1:0]               out_data,
    output logic [$clog2(PORTS)*(PORTS/2)-1:0]   collision
);
    localparam int DST_W  = $clog2(PORTS);
    localparam int STAGES = DST_W;
    localparam int NSW    = PORTS / 2;
    localparam int PKT_W  = 1 + DST_W + PAY_W;

    logic [PORTS*PKT_W-1:0] inj_bus;
    logic [PORTS*PKT_W-1:0] bus [STAGES+1];
    logic [DST_W-1:0]       fin_dst [PORTS];

    always_comb begin
        inj_bus = '0;
        for (int j = 0; j < PORTS; j++) begin
            inj_bus[j*PKT_W +: PKT_W] = {in_valid[j],
                                         in_dest[j*DST_W +: DST_W],
                                         in_data[j*PAY_W +: PAY_W]};
        end
    end

    assign bus[0] = inj_bus;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        omega_stage #(
            .PORTS  (PORTS),
            .DST_W  (DST_W),
            .PAY_W  (PAY_W),
            .SEL_BIT(DST_W - 1 - k),
            .PIPE   (PIPELINE)
        ) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_bus (bus[k]),
            .out_bus(bus[k+1]),
            .col_o  (collision[k*NSW +: NSW])
        );
    end

    always_comb begin
        out_valid = '0;
        out_data  = '0;
        for (int j = 0; j < PORTS; j++) begin
            out_valid[j]               = bus[STAGES][j*PKT_W + PKT_W - 1];
            out_data[j*PAY_W +: PAY_W] = bus[STAGES][j*PKT_W +: PAY_W];
            fin_dst[j]                 = bus[STAGES][j*PKT_W + PAY_W +: DST_W];
        end
    end

    for (genvar j = 0; j < PORTS; j++) begin : g_chk_exit
        assert_exit_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[j] |-> (fin_dst[j] == DST_W'(j)));
    end

    if (!PIPELINE) begin : g_chk_comb
        assert_no_loss_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (collision == '0) |-> ($countones(out_valid) == $countones(in_valid)));
    end

endmodule

// File: tb/omega_net_bench.sv
`timescale 1ns/1ps
module omega_net_bench;
    localparam int P  = 8;
    localparam int DW = 3;
    localparam int PW = 8;
    localparam int S  = 3;
    localparam int NS = P / 2;
    localparam int CW = S * NS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [P-1:0]    in_valid = '0;
    logic [P*DW-1:0] in_dest = '0;
    logic [P*PW-1:0] in_data = '0;

    logic [P-1:0]    c_valid, p_valid;
    logic [P*PW-1:0] c_data, p_data;
    logic [CW-1:0]   c_col, p_col;

    logic [P-1:0]    exp_valid;
    logic [P*PW-1:0] exp_data;
    logic [CW-1:0]   exp_col;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    omega_net #(.PORTS(P), .PAY_W(PW), .PIPELINE(1'b0)) u_omega_net (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
        .in_data(in_data), .out_valid(c_valid), .out_data(c_data), .collision(c_col));

    omega_net #(.PORTS(P), .PAY_W(PW), .PIPELINE(1'b1)) u_omega_net_pipe (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
        .in_data(in_data), .out_valid(p_valid), .out_data(p_data), .collision(p_col));

    // Model: each valid packet leaves a switch on the side named by its
    // routing bit; the packet arriving on the upper side keeps a shared side.
    task automatic model();
        logic cv [P]; int cd [P]; int cp [P];
        logic tv [P]; int td [P]; int tp [P];
        exp_col = '0;
        for (int j = 0; j < P; j++) begin
            cv[j] = in_valid[j];
            cd[j] = int'(in_dest[j*DW +: DW]);
            cp[j] = int'(in_data[j*PW +: PW]);
        end
        for (int k = 0; k < S; k++) begin
            for (int j = 0; j < P; j++) begin
                int n;
                n = ((j * 2) % P) + (j / (P / 2));
                tv[n] = cv[j]; td[n] = cd[j]; tp[n] = cp[j];
            end
            for (int j = 0; j < P; j++) cv[j] = 1'b0;
            for (int i = 0; i < NS; i++) begin
                int ub, lb;
                ub = (td[2*i]   >> (S - 1 - k)) & 1;
                lb = (td[2*i+1] >> (S - 1 - k)) & 1;
                if (tv[2*i]) begin
                    cv[2*i+ub] = 1'b1; cd[2*i+ub] = td[2*i]; cp[2*i+ub] = tp[2*i];
                end
                if (tv[2*i+1]) begin
                    if (tv[2*i] && ub == lb) begin
                        exp_col[k*NS + i] = 1'b1;
                    end else begin
                        cv[2*i+lb] = 1'b1; cd[2*i+lb] = td[2*i+1]; cp[2*i+lb] = tp[2*i+1];
                    end
                end
            end
        end
        exp_data = '0;
        for (int j = 0; j < P; j++) begin
            exp_valid[j] = cv[j];
            if (cv[j]) exp_data[j*PW +: PW] = PW'(cp[j]);
        end
    endtask

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_net(string tag, string who, logic [P-1:0] av,
                             logic [P*PW-1:0] ad, logic [CW-1:0] ac);
        logic [P*PW-1:0] mask;
        mask = '0;
        for (int j = 0; j < P; j++) if (exp_valid[j]) mask[j*PW +: PW] = '1;
        n_tests++;
        if (av !== exp_valid || (ad & mask) !== (exp_data & mask) || ac !== exp_col) begin
            n_fail++;
            $display("FAIL %s %s: valid %h/%h data %h/%h col %h/%h (actual/expected)",
                     tag, who, av, exp_valid, ad & mask, exp_data & mask, ac, exp_col);
        end
    endtask

    task automatic apply_and_check(string tag);
        model();
        repeat (S) @(posedge clk);
        #1;
        check_net(tag, "comb", c_valid, c_data, c_col);
        check_net("R8", "pipe", p_valid, p_data, p_col);
    endtask

    task automatic next_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R9: reset clears registers even with valid inputs present.
        in_valid = '1;
        for (int j = 0; j < P; j++) begin
            in_dest[j*DW +: DW] = DW'(0);
            in_data[j*PW +: PW] = PW'(j + 1);
        end
        repeat (3) @(posedge clk);
        #1;
        chk("R9", "pipe out_valid in reset", 64'(p_valid), 64'h0);
        chk("R9", "pipe collision in reset", 64'(p_col), 64'h0);
        chk("R1", "collision width", 64'($bits(c_col)), 64'(S * NS));

        @(negedge clk);
        in_valid = '0;
        rst_n = 1'b1;
        repeat (S + 1) @(posedge clk);

        // R8: latency, source 2 to destination 5.
        @(negedge clk);
        in_valid = 8'h04;
        in_dest[2*DW +: DW] = 3'd5;
        in_data[2*PW +: PW] = 8'hA5;
        #1;
        chk("R8", "comb same-cycle valid", 64'(c_valid), 64'h20);
        @(posedge clk); #1;
        chk("R8", "pipe valid after 1 edge", 64'(p_valid), 64'h0);
        @(posedge clk); #1;
        chk("R8", "pipe valid after 2 edges", 64'(p_valid), 64'h0);
        @(posedge clk); #1;
        chk("R8", "pipe valid after 3 edges", 64'(p_valid), 64'h20);
        chk("R8", "pipe data after 3 edges", 64'(p_data[5*PW +: PW]), 64'hA5);

        // R3/R7: every single source to every destination.
        for (int s = 0; s < P; s++) begin
            for (int d = 0; d < P; d++) begin
                @(negedge clk);
                in_valid = '0;
                in_valid[s] = 1'b1;
                in_dest = '0;
                in_dest[s*DW +: DW] = DW'(d);
                in_data[s*PW +: PW] = PW'(s * 16 + d);
                apply_and_check("R3");
                chk("R7", "single packet output count", 64'($countones(c_valid)), 64'h1);
                chk("R2", "single packet lands on dest", 64'(c_valid), 64'(1 << d));
            end
        end

        // R2: full-load uniform shifts raise no flag.
        for (int c = 0; c < P; c++) begin
            @(negedge clk);
            in_valid = '1;
            for (int j = 0; j < P; j++) begin
                in_dest[j*DW +: DW] = DW'((j + c) % P);
                in_data[j*PW +: PW] = PW'(8'h40 + j);
            end
            apply_and_check("R2");
            chk("R2", "shift flags clear", 64'(c_col), 64'h0);
            chk("R2", "shift all delivered", 64'(c_valid), 64'hFF);
        end

        // R5: sources 0 and 4 both to destination 0 meet at stage 0 switch 0.
        @(negedge clk);
        in_valid = 8'h11;
        in_dest = '0;
        in_data = '0;
        in_data[0*PW +: PW] = 8'hC0;
        in_data[4*PW +: PW] = 8'hC4;
        apply_and_check("R5");
        chk("R5", "stage0 sw0 flag", 64'(c_col), 64'h1);
        chk("R5", "upper packet survives", 64'(c_valid), 64'h01);
        chk("R5", "survivor payload", 64'(c_data[0 +: PW]), 64'hC0);

        // R6: same pair, upper invalid: lower is free to route.
        @(negedge clk);
        in_valid = 8'h10;
        apply_and_check("R6");
        chk("R6", "no flag with invalid partner", 64'(c_col), 64'h0);
        chk("R6", "lower packet delivered", 64'(c_valid), 64'h01);
        chk("R6", "lower payload", 64'(c_data[0 +: PW]), 64'hC4);

        // R4: random mixes of valid bits and destinations.
        for (int r = 0; r < 400; r++) begin
            @(negedge clk);
            next_rand();
            in_valid = seed[7:0];
            next_rand();
            in_dest = seed[P*DW-1:0];
            next_rand();
            in_data[31:0] = seed;
            next_rand();
            in_data[63:32] = seed;
            apply_and_check("R4");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule